// File: doc/BRIEF.md
# Stack and Subroutine Call Sequencer

This block is the multi-cycle execution unit for the stack family of a small 8-bit processor with a 16-bit address space. When the fetch logic has an opcode from the extended family, it hands the opcode to the unit together with the current program counter and the three general register values. The unit then drives the memory bus for two to five cycles. At the end it returns a register write-back, the address at which fetch must resume, and a one-cycle `done` pulse. The unit owns the stack pointer, which grows toward higher addresses, and a temporary byte used to assemble 16-bit addresses.

The handoff is a valid/ready handshake. An opcode is taken when `issue_valid` and `issue_ready` are both high at a rising edge. `issue_ready` falls in the following cycle and stays low while the instruction runs, so the fetch side must hold or re-present its request until ready returns. Ready returns in the same cycle as `done`. The opcode, program counter and register values are captured only at that accepting edge. After that they may change freely.

Memory reads have a one-cycle latency. The unit registers `mem_addr` and `mem_re`, and the memory must present the byte on `mem_rdata` before the clock edge that ends that cycle. The unit samples the byte on that edge. Writes take effect on the edge that ends the cycle in which `mem_we` is high.

Top module: `stk_call_unit`

## Requirements
- R1: After reset, `mem_we`, `mem_re`, `done` and `wb_en` are low, `issue_ready` is high and the stack pointer is 0, so the first push writes address 0x0000.
- R2: An opcode is accepted when `issue_valid` and `issue_ready` are high at an edge. `issue_ready` is low from the next cycle until the `done` cycle, in which it is high again. While busy, `issue_valid` is ignored. The opcode, `pc_in` and `reg_a`/`reg_b`/`reg_c` are sampled only at the accepting edge.
- R3: Opcodes 0xF0, 0xF1 and 0xF2 push A, B and C. In the cycle after acceptance, `mem_we` is high, `mem_addr` is the stack pointer and `mem_wdata` is the register value. In the next cycle, `done` is high, `pc_next` is pc+1 and the stack pointer has grown by 1.
- R4: Opcodes 0xF3, 0xF4 and 0xF5 pop into A, B and C. In the cycle after acceptance, `mem_re` is high and `mem_addr` is the stack pointer minus 1, which is also the new stack pointer. In the next cycle, `done` is high, `pc_next` is pc+1 and `wb_en` is one-hot: bit 0 for A, bit 1 for B, bit 2 for C.
- R5: Opcode 0xF6 (call) runs for five cycles after acceptance, with R = pc+3. Cycle 1 writes R[15:8] at the stack pointer. Cycle 2 writes R[7:0] at the stack pointer plus 1. Cycles 3 and 4 read pc+1 and then pc+2. Cycle 5 raises `done` with `pc_next` = {byte at pc+1, byte at pc+2}. The stack pointer grows by 2.
- R6: Opcode 0xF7 (return) runs for three cycles after acceptance. It reads the stack pointer minus 1 and then minus 2. Cycle 3 raises `done` with `pc_next` = {byte at sp−2, byte at sp−1}. The stack pointer shrinks by 2.
- R7: Any opcode whose high nibble is not 0xF, and 0xF8 through 0xFF, is a no-op. `done` rises in the cycle after acceptance, `pc_next` is pc+1, no strobe is raised and the stack pointer is unchanged.
- R8: `mem_we` and `mem_re` are never high together. `wb_en` has at most one bit set and is nonzero only in a `done` cycle.
- R9: The stack pointer wraps modulo 2^16. A pop at pointer 0 reads 0xFFFF, and a push at 0xFFFF leaves the pointer at 0.
- R10: Read data is taken from `mem_rdata` at the edge that ends a cycle in which `mem_re` is high. A popped register, and the bytes that form a call or return target, are the bytes the memory presented then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Fetch side offers an opcode |
| issue_ready | output | 1 | Unit can accept an opcode |
| issue_op | input | 8 | Opcode to execute |
| pc_in | input | 16 | Address of the offered opcode |
| reg_a | input | 8 | Current value of register A |
| reg_b | input | 8 | Current value of register B |
| reg_c | input | 8 | Current value of register C |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| done | output | 1 | Last cycle of the instruction |
| pc_next | output | 16 | Address where fetch resumes, valid with done |
| wb_en | output | 3 | One-hot register write-back enable (A, B, C) |
| wb_data | output | 8 | Register write-back value |

## Verification
A stack pointer that is off by one shows up on the bus in the first cycle of the next stack access: `mem_addr` of a push or pop, or the return-address write of a call, lands one byte away from the address the bench tracks. A wrong cycle counter or a misdecoded opcode shows up as a strobe pattern of the wrong length, or as `done` one cycle early or late. A byte-order error in the temporary register shows up in `pc_next` on the `done` cycle of a call or return. Each check is made in the exact cycle where the value must appear, so a fault is reported within the instruction that exposes it.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Instruction classes handled by the sequencer.
  typedef enum logic [2:0] {
    OPK_PUSH = 3'd0,
    OPK_POP  = 3'd1,
    OPK_CALL = 3'd2,
    OPK_RET  = 3'd3,
    OPK_NOP  = 3'd4
  } op_kind_e;

  // Stack pointer update requested for the current edge.
  typedef enum logic [1:0] {
    SPC_HOLD = 2'd0,
    SPC_INC  = 2'd1,
    SPC_DEC  = 2'd2,
    SPC_ADD2 = 2'd3
  } sp_cmd_e;

  // Index of the final cycle of each class (cycle 0 runs on the accepting edge).
  localparam int unsigned LAST_PUSH = 1;
  localparam int unsigned LAST_POP  = 1;
  localparam int unsigned LAST_CALL = 4;
  localparam int unsigned LAST_RET  = 2;
  localparam int unsigned LAST_NOP  = 0;

endpackage

// File: rtl/stk_opdec.sv
module stk_opdec
  import stk_pkg::*;
#(
  parameter int unsigned NREGS  = 3,
  parameter int unsigned CW     = 3,
  parameter logic [3:0]  FAMILY = 4'hF,
  localparam int unsigned RSW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic [7:0]     op,
  output op_kind_e       kind,
  output logic [RSW-1:0] rsel,
  output logic [CW-1:0]  last
);

  localparam logic [3:0] PUSH_END = 4'(NREGS);
  localparam logic [3:0] POP_END  = 4'(2 * NREGS);
  localparam logic [3:0] CALL_CODE = 4'(2 * NREGS);
  localparam logic [3:0] RET_CODE  = 4'(2 * NREGS + 1);

  logic [3:0] code;
  logic       in_family;

  assign code      = op[3:0];
  assign in_family = (op[7:4] == FAMILY);

  always_comb begin
    kind = OPK_NOP;
    rsel = '0;
    last = CW'(LAST_NOP);
    if (in_family) begin
      if (code < PUSH_END) begin
        kind = OPK_PUSH;
        rsel = RSW'(code);
        last = CW'(LAST_PUSH);
      end else if (code < POP_END) begin
        kind = OPK_POP;
        rsel = RSW'(code - PUSH_END);
        last = CW'(LAST_POP);
      end else if (code == CALL_CODE) begin
        kind = OPK_CALL;
        last = CW'(LAST_CALL);
      end else if (code == RET_CODE) begin
        kind = OPK_RET;
        last = CW'(LAST_RET);
      end
    end
  end

endmodule

// File: rtl/stk_sp.sv
module stk_sp
  import stk_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_cmd_e       cmd,
  output logic [AW-1:0] sp
);

  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else begin
      unique case (cmd)
        SPC_INC:  sp <= sp + ONE;
        SPC_DEC:  sp <= sp - ONE;
        SPC_ADD2: sp <= sp + TWO;
        default:  sp <= sp;
      endcase
    end
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned NREGS = 3,
  parameter int unsigned CW    = 3,
  localparam int unsigned RSW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  op_kind_e         dec_kind,
  input  logic [RSW-1:0]   dec_rsel,
  input  logic [CW-1:0]    dec_last,
  input  logic [AW-1:0]    pc_in,
  input  logic [DW-1:0]    push_val,
  input  logic [AW-1:0]    sp,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output sp_cmd_e          sp_cmd,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  output logic             done,
  output logic [AW-1:0]    pc_next,
  output logic [NREGS-1:0] wb_en,
  output logic [DW-1:0]    wb_data
);

  localparam logic [AW-1:0] ONE      = AW'(1);
  localparam logic [AW-1:0] TWO      = AW'(2);
  localparam logic [AW-1:0] CALL_LEN = AW'(3);

  // Latched instruction context
  op_kind_e       kind_q;
  logic [RSW-1:0] rsel_q;
  logic [CW-1:0]  last_q;
  logic [CW-1:0]  cyc_q;
  logic [AW-1:0]  base_q;
  logic [DW-1:0]  tmp_q;

  // Context of the cycle being executed at the coming edge
  op_kind_e       a_kind;
  logic [RSW-1:0] a_rsel;
  logic [CW-1:0]  a_cyc;
  logic [CW-1:0]  a_last;
  logic [AW-1:0]  a_base;
  logic [AW-1:0]  base_now;
  logic           a_en;
  logic           is_last;
  logic [NREGS-1:0] hit;

  // Next-state values
  logic             n_busy;
  logic [CW-1:0]    n_cyc;
  logic [AW-1:0]    n_base;
  logic [DW-1:0]    n_tmp;
  logic [AW-1:0]    n_addr;
  logic [DW-1:0]    n_wdata;
  logic             n_we;
  logic             n_re;
  logic             n_done;
  logic [AW-1:0]    n_pc;
  logic [NREGS-1:0] n_wb;
  logic [DW-1:0]    n_wbdata;

  assign base_now = pc_in + ((dec_kind == OPK_CALL) ? CALL_LEN : ONE);
  assign a_en     = accept | busy;
  assign a_kind   = accept ? dec_kind : kind_q;
  assign a_rsel   = accept ? dec_rsel : rsel_q;
  assign a_cyc    = accept ? '0       : cyc_q;
  assign a_last   = accept ? dec_last : last_q;
  assign a_base   = accept ? base_now : base_q;
  assign is_last  = (a_cyc == a_last);

  for (genvar g = 0; g < NREGS; g++) begin : g_sel
    assign hit[g] = (a_rsel == RSW'(g));
  end

  always_comb begin
    n_busy   = busy;
    n_cyc    = cyc_q;
    n_base   = base_q;
    n_tmp    = tmp_q;
    n_addr   = mem_addr;
    n_wdata  = mem_wdata;
    n_we     = 1'b0;
    n_re     = 1'b0;
    n_done   = 1'b0;
    n_pc     = pc_next;
    n_wb     = '0;
    n_wbdata = wb_data;
    sp_cmd   = SPC_HOLD;
    if (a_en) begin
      n_busy = !is_last;
      n_cyc  = a_cyc + CW'(1);
      n_done = is_last;
      n_base = a_base;
      unique case (a_kind)
        OPK_PUSH: begin
          if (a_cyc == CW'(0)) begin
            n_we    = 1'b1;
            n_addr  = sp;
            n_wdata = push_val;
          end else begin
            sp_cmd = SPC_INC;
            n_pc   = a_base;
          end
        end
        OPK_POP: begin
          if (a_cyc == CW'(0)) begin
            n_re   = 1'b1;
            n_addr = sp - ONE;
            sp_cmd = SPC_DEC;
          end else begin
            n_wb     = hit;
            n_wbdata = mem_rdata;
            n_pc     = a_base;
          end
        end
        OPK_CALL: begin
          case (a_cyc)
            CW'(0): begin
              n_we    = 1'b1;
              n_addr  = sp;
              n_wdata = a_base[AW-1 -: DW];
            end
            CW'(1): begin
              n_we    = 1'b1;
              n_addr  = sp + ONE;
              n_wdata = a_base[DW-1:0];
            end
            CW'(2): begin
              n_re   = 1'b1;
              n_addr = a_base - TWO;
              sp_cmd = SPC_ADD2;
            end
            CW'(3): begin
              n_re   = 1'b1;
              n_addr = a_base - ONE;
              n_tmp  = mem_rdata;
            end
            default: begin
              n_pc = AW'({tmp_q, mem_rdata});
            end
          endcase
        end
        OPK_RET: begin
          case (a_cyc)
            CW'(0): begin
              n_re   = 1'b1;
              n_addr = sp - ONE;
              sp_cmd = SPC_DEC;
            end
            CW'(1): begin
              n_re   = 1'b1;
              n_addr = sp - ONE;
              n_tmp  = mem_rdata;
              sp_cmd = SPC_DEC;
            end
            default: begin
              n_pc = AW'({mem_rdata, tmp_q});
            end
          endcase
        end
        default: begin
          n_pc = a_base;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cyc_q     <= '0;
      kind_q    <= OPK_NOP;
      rsel_q    <= '0;
      last_q    <= '0;
      base_q    <= '0;
      tmp_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      done      <= 1'b0;
      pc_next   <= '0;
      wb_en     <= '0;
      wb_data   <= '0;
    end else begin
      busy      <= n_busy;
      cyc_q     <= n_cyc;
      base_q    <= n_base;
      tmp_q     <= n_tmp;
      mem_addr  <= n_addr;
      mem_wdata <= n_wdata;
      mem_we    <= n_we;
      mem_re    <= n_re;
      done      <= n_done;
      pc_next   <= n_pc;
      wb_en     <= n_wb;
      wb_data   <= n_wbdata;
      if (accept) begin
        kind_q <= dec_kind;
        rsel_q <= dec_rsel;
        last_q <= dec_last;
      end
    end
  end

endmodule

// File: rtl/stk_call_unit.sv
module stk_call_unit
  import stk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [7:0]    issue_op,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] reg_a,
  input  logic [DW-1:0] reg_b,
  input  logic [DW-1:0] reg_c,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] pc_next,
  output logic [2:0]    wb_en,
  output logic [DW-1:0] wb_data
);

  localparam int unsigned NREGS = 3;
  localparam int unsigned CW    = 3;
  localparam int unsigned RSW   = $clog2(NREGS);

  op_kind_e       dec_kind;
  logic [RSW-1:0] dec_rsel;
  logic [CW-1:0]  dec_last;
  logic [DW-1:0]  push_val;
  logic [AW-1:0]  sp;
  sp_cmd_e        sp_cmd;
  logic           busy;
  logic           accept;

  assign issue_ready = !busy;
  assign accept      = issue_valid && issue_ready;

  always_comb begin
    unique case (dec_rsel)
      RSW'(1): push_val = reg_b;
      RSW'(2): push_val = reg_c;
      default: push_val = reg_a;
    endcase
  end

  stk_opdec #(
    .NREGS (NREGS),
    .CW    (CW)
  ) u_dec (
    .op   (issue_op),
    .kind (dec_kind),
    .rsel (dec_rsel),
    .last (dec_last)
  );

  stk_sp #(
    .AW (AW)
  ) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (sp_cmd),
    .sp    (sp)
  );

  stk_seq #(
    .AW    (AW),
    .DW    (DW),
    .NREGS (NREGS),
    .CW    (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .dec_kind  (dec_kind),
    .dec_rsel  (dec_rsel),
    .dec_last  (dec_last),
    .pc_in     (pc_in),
    .push_val  (push_val),
    .sp        (sp),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .sp_cmd    (sp_cmd),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .pc_next   (pc_next),
    .wb_en     (wb_en),
    .wb_data   (wb_data)
  );

endmodule

// File: rtl/stk_call_unit_chk.sv
module stk_call_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue_valid,
  input logic       issue_ready,
  input logic [7:0] issue_op,
  input logic       mem_we,
  input logic       mem_re,
  input logic       done,
  input logic [2:0] wb_en
);

  logic take;
  logic fam;
  assign take = issue_valid && issue_ready;
  assign fam  = (issue_op[7:4] == 4'hF);

  // R2: ready is back in the cycle that carries done
  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> issue_ready);

  // R3: push writes once, then completes
  p_push_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fam && issue_op[3:0] < 4'd3)
    |=> (mem_we && !mem_re && !issue_ready) ##1 (done && !mem_we && issue_ready));

  // R4: pop reads once, then completes with a single write-back
  p_pop_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fam && issue_op[3:0] >= 4'd3 && issue_op[3:0] < 4'd6)
    |=> (mem_re && !mem_we && !issue_ready) ##1 (done && !mem_re && $countones(wb_en) == 1));

  // R5: call writes twice, reads twice, then completes
  p_call_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && issue_op == 8'hF6)
    |=> mem_we ##1 mem_we ##1 mem_re ##1 mem_re ##1 (done && !mem_re && !mem_we));

  // R6: return reads twice, then completes
  p_ret_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && issue_op == 8'hF7)
    |=> (mem_re && !done) ##1 (mem_re && !done) ##1 (done && !mem_re));

  // R7: codes outside the eight handled ones finish at once without bus traffic
  p_nop_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(fam && !issue_op[3]))
    |=> (done && !mem_we && !mem_re && wb_en == 3'b000));

  // R8: strobes are exclusive
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R8: write-back only with done, never more than one register
  p_wb_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en != 3'b000) |-> (done && $onehot0(wb_en)));

endmodule

bind stk_call_unit stk_call_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_op    (issue_op),
  .mem_we      (mem_we),
  .mem_re      (mem_re),
  .done        (done),
  .wb_en       (wb_en)
);

// File: tb/tb_stk_call_unit.sv
module tb_stk_call_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [7:0]  issue_op;
  logic [15:0] pc_in;
  logic [7:0]  reg_a, reg_b, reg_c;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [15:0] pc_next;
  logic [2:0]  wb_en;
  logic [7:0]  wb_data;

  always #5 clk = ~clk;

  stk_call_unit dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .pc_in(pc_in), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .pc_next(pc_next), .wb_en(wb_en), .wb_data(wb_data)
  );

  // Sparse memory: bit 15 plus low 7 address bits
  logic [7:0] mem [0:255];
  function automatic logic [7:0] mi(input logic [15:0] a);
    return {a[15], a[6:0]};
  endfunction
  assign mem_rdata = mem[mi(mem_addr)];

  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;
  logic [15:0] ref_sp;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc, output logic [15:0] got_pc);
    logic [7:0]  rv [3];
    bit          ew [8];
    bit          er [8];
    logic [15:0] ea [8];
    logic [7:0]  ed [8];
    logic [15:0] epc, s, r, nsp;
    logic [2:0]  ewb;
    logic [7:0]  ewbd;
    string       tag;
    int          n;
    rv[0] = reg_a; rv[1] = reg_b; rv[2] = reg_c;
    for (int i = 0; i < 8; i++) begin ew[i] = 0; er[i] = 0; ea[i] = '0; ed[i] = '0; end
    s = ref_sp; ewb = 3'b000; ewbd = 8'h00;
    if (op[7:4] == 4'hF && op[3:0] < 4'd3) begin
      tag = "R3"; n = 2;
      ew[1] = 1; ea[1] = s; ed[1] = rv[op[1:0]];
      epc = pc + 16'd1; nsp = s + 16'd1;
    end else if (op[7:4] == 4'hF && op[3:0] < 4'd6) begin
      tag = "R4"; n = 2;
      er[1] = 1; ea[1] = s - 16'd1;
      ewb = 3'(1 << (op[3:0] - 4'd3)); ewbd = mem[mi(s - 16'd1)];
      epc = pc + 16'd1; nsp = s - 16'd1;
    end else if (op == 8'hF6) begin
      tag = "R5"; n = 5; r = pc + 16'd3;
      ew[1] = 1; ea[1] = s;          ed[1] = r[15:8];
      ew[2] = 1; ea[2] = s + 16'd1;  ed[2] = r[7:0];
      er[3] = 1; ea[3] = pc + 16'd1;
      er[4] = 1; ea[4] = pc + 16'd2;
      epc = {mem[mi(pc + 16'd1)], mem[mi(pc + 16'd2)]}; nsp = s + 16'd2;
    end else if (op == 8'hF7) begin
      tag = "R6"; n = 3;
      er[1] = 1; ea[1] = s - 16'd1;
      er[2] = 1; ea[2] = s - 16'd2;
      epc = {mem[mi(s - 16'd2)], mem[mi(s - 16'd1)]}; nsp = s - 16'd2;
    end else begin
      tag = "R7"; n = 1;
      epc = pc + 16'd1; nsp = s;
    end

    @(negedge clk);
    issue_op = op; pc_in = pc; issue_valid = 1'b1;
    chk(issue_ready == 1'b1, "R2", "ready before issue", 32'(issue_ready), 32'd1);
    @(posedge clk);
    #1;
    // Keep offering a different request and disturb operands while busy (R2)
    issue_op = (op == 8'hF6) ? 8'hF7 : 8'hF6;
    pc_in = ~pc; reg_a = ~rv[0]; reg_b = ~rv[1]; reg_c = ~rv[2];
    got_pc = '0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == n) issue_valid = 1'b0;
      chk(mem_we == ew[k], tag, $sformatf("we cycle %0d", k), 32'(mem_we), 32'(ew[k]));
      chk(mem_re == er[k], tag, $sformatf("re cycle %0d", k), 32'(mem_re), 32'(er[k]));
      chk(!(mem_we && mem_re), "R8", "strobes together", {mem_we, mem_re}, 32'd0);
      if (ew[k] || er[k])
        chk(mem_addr == ea[k], tag, $sformatf("addr cycle %0d", k), 32'(mem_addr), 32'(ea[k]));
      if (ew[k]) begin
        chk(mem_wdata == ed[k], tag, $sformatf("wdata cycle %0d", k), 32'(mem_wdata), 32'(ed[k]));
        mem[mi(mem_addr)] = mem_wdata;
      end
      chk(done == (k == n), tag, $sformatf("done cycle %0d", k), 32'(done), 32'(k == n));
      chk(issue_ready == (k == n), "R2", $sformatf("ready cycle %0d", k), 32'(issue_ready), 32'(k == n));
      chk(wb_en == ((k == n) ? ewb : 3'b000), "R8", "wb_en", 32'(wb_en), 32'((k == n) ? ewb : 3'b000));
      if (k == n) begin
        chk(pc_next == epc, tag, "pc_next", 32'(pc_next), 32'(epc));
        if (ewb != 3'b000)
          chk(wb_data == ewbd, "R10", "popped byte", 32'(wb_data), 32'(ewbd));
        got_pc = pc_next;
      end
    end
    reg_a = rv[0]; reg_b = rv[1]; reg_c = rv[2];
    ref_sp = nsp;
  endtask

  logic [15:0] gp;
  logic [7:0]  pushed [48];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = 8'h00; pc_in = 16'h0000;
    reg_a = 8'h00; reg_b = 8'h00; reg_c = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ref_sp = 16'h0000;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(mem_we == 1'b0, "R1", "we after reset", 32'(mem_we), 32'd0);
    chk(mem_re == 1'b0, "R1", "re after reset", 32'(mem_re), 32'd0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    chk(wb_en == 3'b000, "R1", "wb_en after reset", 32'(wb_en), 32'd0);
    chk(issue_ready == 1'b1, "R1", "ready after reset", 32'(issue_ready), 32'd1);

    // Worked program: push A, call 0x8007, return (R1 first push at 0)
    reg_a = 8'hDE;
    mem[mi(16'h8004)] = 8'h80; mem[mi(16'h8005)] = 8'h07;
    run_op(8'hF0, 16'h8002, gp);
    chk(mem[mi(16'h0000)] == 8'hDE, "R1", "first push at 0", 32'(mem[mi(16'h0000)]), 32'hDE);
    run_op(8'hF6, 16'h8003, gp);
    chk(gp == 16'h8007, "R5", "call target", 32'(gp), 32'h8007);
    chk(mem[mi(16'h0001)] == 8'h80, "R5", "return hi byte", 32'(mem[mi(16'h0001)]), 32'h80);
    chk(mem[mi(16'h0002)] == 8'h06, "R5", "return lo byte", 32'(mem[mi(16'h0002)]), 32'h06);
    run_op(8'hF7, 16'h800B, gp);
    chk(gp == 16'h8006, "R6", "return address", 32'(gp), 32'h8006);
    reg_a = 8'h00;
    run_op(8'hF3, 16'h8006, gp);
    chk(wb_data == 8'hDE, "R4", "pop after return", 32'(wb_data), 32'hDE);

    // Push sweep over all three registers, then pop back in reverse
    for (int i = 0; i < 48; i++) begin
      logic [7:0] v;
      v = 8'(i * 53 + 7);
      pushed[i] = v;
      reg_a = v; reg_b = v; reg_c = v;
      run_op(8'hF0 + 8'(i % 3), 16'h8020 + 16'(i), gp);
    end
    for (int i = 47; i >= 0; i--) begin
      run_op(8'hF3 + 8'(i % 3), 16'h8030, gp);
      chk(wb_data == pushed[i], "R4", "LIFO order", 32'(wb_data), 32'(pushed[i]));
    end

    // No-op sweep over every other opcode
    for (int op = 0; op < 256; op++) begin
      if (!(op[7:4] == 4'hF && op[3] == 1'b0))
        run_op(8'(op), 16'(op * 257), gp);
    end

    // Nested calls and returns
    for (int t = 0; t < 8; t++) begin
      logic [15:0] p;
      p = 16'h8010 + 16'(3 * t);
      mem[mi(p + 16'd1)] = 8'h90 + 8'(t);
      mem[mi(p + 16'd2)] = 8'(t * 17);
      run_op(8'hF6, p, gp);
      chk(gp == {8'h90 + 8'(t), 8'(t * 17)}, "R5", "nested target", 32'(gp), 32'({8'h90 + 8'(t), 8'(t * 17)}));
    end
    for (int t = 7; t >= 0; t--) begin
      run_op(8'hF7, 16'h8070, gp);
      chk(gp == 16'h8013 + 16'(3 * t), "R6", "nested return", 32'(gp), 32'(16'h8013 + 16'(3 * t)));
    end

    // Pointer wrap at zero
    chk(ref_sp == 16'h0000, "R9", "pointer back at 0", 32'(ref_sp), 32'd0);
    mem[mi(16'hFFFF)] = 8'h3C;
    run_op(8'hF3, 16'h8040, gp);
    chk(wb_data == 8'h3C, "R9", "pop at 0 reads 0xFFFF", 32'(wb_data), 32'h3C);
    reg_b = 8'hA1; reg_c = 8'hB2;
    run_op(8'hF1, 16'h8041, gp);
    run_op(8'hF2, 16'h8042, gp);
    chk(mem[mi(16'h0000)] == 8'hB2, "R9", "push after wrap at 0", 32'(mem[mi(16'h0000)]), 32'hB2);
    run_op(8'hF7, 16'h8043, gp);
    chk(gp == 16'hA1B2, "R9", "return across wrap", 32'(gp), 32'hA1B2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule